// File: doc/BRIEF.md
# Time-Sliced Crossbar Interconnect

This block moves words between a memory port and an array of datapath units. The units run on a slow clock. The crossbar runs on a fast clock four times quicker and spends each fast cycle on one slot of a slow period. A small set of shared lanes is therefore reused four times per slow cycle instead of wiring every destination in parallel. In each slot, a lane picks one source and delivers it to one destination. A source is the memory read word, a unit output, or a unit output held back by one slow cycle. A destination is a unit input or the memory write port.

Each destination gathers what its lanes deliver during a slow period. At the end of the last slot it presents that word, with a valid flag, for the whole following slow period. The held-back copies of unit outputs let a chain of units form a pipeline that starts with a memory read and ends with a memory write, with one slow-cycle stage between units. Routing is static configuration. Software loads it into a shadow table while an enable is raised, and the live table takes the new contents at the next slow-cycle boundary.

Top module: `tmx_crossbar`

## Requirements
- R1: The fast cycle in which `slow_sync` is high is slot 0. The slots that follow count 1, 2 and 3 and then wrap to slot 0 by themselves; a `slow_sync` pulse always forces slot 0, even in the middle of a period.
- R2: In slot s, each lane whose live entry holds a valid source and a valid destination delivers the source word sampled in that fast cycle. Source codes are: 0 idle, 1 `mem_rdata`, 2+k output of unit k, 2+NUM_UNITS+k held-back output of unit k. Destination codes are: 0 idle, 1+k input of unit k, NUM_UNITS+1 memory write port.
- R3: The destination outputs (`unit_in`, `unit_in_vld`, `mem_wdata`, `mem_wvalid`) change only on the clock edge that ends the last slot. They hold for the next four fast cycles.
- R4: When a destination is written more than once in one slow period, a later slot replaces an earlier one. Within one slot, the higher lane index wins.
- R5: A destination that receives no delivery during a slow period presents zero data with its valid flag low for the next period.
- R6: The held-back source of unit k yields the value `unit_out` of unit k had in the last slot of the previous slow period.
- R7: A table write happens only when `cfg_en` and `cfg_wr` are both high. A `cfg_wr` pulse while `cfg_en` is low leaves routing unchanged.
- R8: Table writes go to a shadow copy. The live table copies the shadow on the edge that ends the last slot, so a write never alters routing within the slow period in which it happens.
- R9: After a synchronous reset, all destinations present zero with valid low, every table entry is idle, the slot count is 0 and the held-back registers are zero.
- R10: A source code above 2*NUM_UNITS+1 or a destination code above NUM_UNITS+1 makes that lane idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast crossbar clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_sync | input | 1 | High in the fast cycle aligned with the slow clock's rising edge (slot 0) |
| mem_rdata | input | DATA_W | Memory read word |
| unit_out | input | NUM_UNITS*DATA_W | Outputs of the datapath units, unit k at bits k*DATA_W |
| cfg_en | input | 1 | Configuration enable |
| cfg_wr | input | 1 | Table write strobe |
| cfg_slot | input | SLOT_W | Slot of the entry being written |
| cfg_lane | input | LANE_W | Lane of the entry being written |
| cfg_src | input | SRC_W | Source code for the entry |
| cfg_dst | input | DST_W | Destination code for the entry |
| unit_in | output | NUM_UNITS*DATA_W | Held input words for the units |
| unit_in_vld | output | NUM_UNITS | Valid flag per unit input |
| mem_wdata | output | DATA_W | Held memory write word |
| mem_wvalid | output | 1 | Memory write valid |

## Verification
On every cycle, the embedded assertions check the slot advance after a sync pulse and the wrap after the last slot. They also check that the shadow table moves only under an enabled write, that the live table and the destination outputs move only at the period boundary, and that an invalid destination carries zero. Which word reaches which destination, the overwrite order across lanes and slots, the one-period lag of held-back sources and the handling of out-of-range codes can only be shown by the bench's scenarios. Those scenarios compare every fast cycle against an independent model, while syncing, free-running and shifting the slot phase.

// File: rtl/xbar_pkg.sv
// Package: shared code values and sizing helpers for the time-sliced crossbar.
// Assumes: the source code space is idle, memory, direct units, then held units.
package xbar_pkg;

    localparam int SRC_IDLE      = 0;
    localparam int SRC_MEM       = 1;
    localparam int SRC_UNIT_BASE = 2;
    localparam int DST_IDLE      = 0;

    // Number of distinct source codes for n units
    function automatic int src_codes(input int n);
        return 2 * n + 2;
    endfunction

    // Number of distinct destination codes for n units
    function automatic int dst_codes(input int n);
        return n + 2;
    endfunction

    // Bits needed to encode v distinct values (at least one)
    function automatic int bits_for(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/xbar_slot_seq.sv
// Module: slot sequencer. Counts fast cycles within a slow period.
// Assumes: slow_sync marks slot 0 and is free to arrive at any phase; the
// count wraps by itself when no sync arrives.
module xbar_slot_seq #(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_sync,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              boundary
);

    logic [SLOT_W-1:0] slot_q;

    // Current slot: a sync pulse overrides the running count
    always_comb begin
        cur_slot = slow_sync ? '0 : slot_q;
        boundary = (cur_slot == SLOT_W'(SLOTS - 1));
    end

    // Advance the count, wrapping after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (boundary)
            slot_q <= '0;
        else
            slot_q <= cur_slot + SLOT_W'(1);
    end

    assert_sync_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_sync ##1 !slow_sync) |-> (cur_slot == SLOT_W'(1)));

    assert_wrap_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (cur_slot == '0));

endmodule

// File: rtl/xbar_route_table.sv
// Module: routing table with a shadow copy for writes and a live copy for use.
// Assumes: writes need cfg_en and cfg_wr together; the live copy reloads only
// at the period boundary, so routing is constant within a slow period.
module xbar_route_table #(
    parameter int SLOTS  = 4,
    parameter int LANES  = 2,
    parameter int SLOT_W = 2,
    parameter int LANE_W = 1,
    parameter int SRC_W  = 4,
    parameter int DST_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   boundary,
    input  logic [SLOT_W-1:0]      cur_slot,
    input  logic                   cfg_en,
    input  logic                   cfg_wr,
    input  logic [SLOT_W-1:0]      cfg_slot,
    input  logic [LANE_W-1:0]      cfg_lane,
    input  logic [SRC_W-1:0]       cfg_src,
    input  logic [DST_W-1:0]       cfg_dst,
    output logic [LANES*SRC_W-1:0] lane_src,
    output logic [LANES*DST_W-1:0] lane_dst
);

    localparam int ENTRY_W = SRC_W + DST_W;
    localparam int TBL_W   = SLOTS * LANES * ENTRY_W;

    logic [TBL_W-1:0] shadow_q;
    logic [TBL_W-1:0] active_q;
    logic             wr_ok;

    // Accept a write only when enabled and addressing a real entry
    always_comb begin
        wr_ok = cfg_en && cfg_wr && (int'(cfg_slot) < SLOTS) && (int'(cfg_lane) < LANES);
    end

    // Shadow copy takes software writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr_ok)
            shadow_q[(int'(cfg_slot) * LANES + int'(cfg_lane)) * ENTRY_W +: ENTRY_W] <= {cfg_src, cfg_dst};
    end

    // Live copy reloads from the shadow at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (boundary)
            active_q <= shadow_q;
    end

    // Present the entry of every lane for the current slot
    for (genvar l = 0; l < LANES; l++) begin : g_lane_rd
        assign lane_src[l*SRC_W +: SRC_W] = active_q[(int'(cur_slot) * LANES + l) * ENTRY_W + DST_W +: SRC_W];
        assign lane_dst[l*DST_W +: DST_W] = active_q[(int'(cur_slot) * LANES + l) * ENTRY_W +: DST_W];
    end

    assert_shadow_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && cfg_wr) |=> $stable(shadow_q));

    assert_live_only_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(active_q));

endmodule

// File: rtl/xbar_lane_mux.sv
// Module: one lane of the crossbar. Picks the source word named by the slot
// entry and passes on a cleaned destination code.
// Assumes: out-of-range or idle codes turn the lane idle (destination 0).
module xbar_lane_mux
    import xbar_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int DATA_W    = 16,
    parameter int SRC_W     = 4,
    parameter int DST_W     = 3
) (
    input  logic [SRC_W-1:0]            src,
    input  logic [DST_W-1:0]            dst,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic [NUM_UNITS*DATA_W-1:0] unit_out,
    input  logic [NUM_UNITS*DATA_W-1:0] unit_dly,
    output logic [DATA_W-1:0]           lane_data,
    output logic [DST_W-1:0]            lane_dst
);

    logic src_ok;

    // Source selection across memory, direct units and held-back units
    always_comb begin
        lane_data = '0;
        src_ok    = 1'b0;
        if (src == SRC_W'(SRC_MEM)) begin
            lane_data = mem_rdata;
            src_ok    = 1'b1;
        end
        for (int k = 0; k < NUM_UNITS; k++) begin
            if (src == SRC_W'(SRC_UNIT_BASE + k)) begin
                lane_data = unit_out[k*DATA_W +: DATA_W];
                src_ok    = 1'b1;
            end
            if (src == SRC_W'(SRC_UNIT_BASE + NUM_UNITS + k)) begin
                lane_data = unit_dly[k*DATA_W +: DATA_W];
                src_ok    = 1'b1;
            end
        end
    end

    // Destination survives only with a usable source and an in-range code
    always_comb begin
        if (src_ok && (int'(dst) <= NUM_UNITS + 1))
            lane_dst = dst;
        else
            lane_dst = DST_W'(DST_IDLE);
    end

endmodule

// File: rtl/xbar_dest_hold.sv
// Module: per-destination staging and presentation registers.
// Assumes: lane_dst code 1+d targets destination d; a later lane index wins
// inside a slot; at the boundary the gathered word moves to the outputs and
// staging clears.
module xbar_dest_hold #(
    parameter int NDST   = 5,
    parameter int LANES  = 2,
    parameter int DATA_W = 16,
    parameter int DST_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    boundary,
    input  logic [LANES*DATA_W-1:0] lane_data,
    input  logic [LANES*DST_W-1:0]  lane_dst,
    output logic [NDST*DATA_W-1:0]  out_data,
    output logic [NDST-1:0]         out_vld
);

    logic [NDST*DATA_W-1:0] stg_data_q;
    logic [NDST-1:0]        stg_vld_q;
    logic [NDST*DATA_W-1:0] hit_data;
    logic [NDST-1:0]        hit;
    logic [NDST*DATA_W-1:0] out_data_q;
    logic [NDST-1:0]        out_vld_q;

    // Decode lane deliveries per destination, higher lane last so it wins
    always_comb begin
        hit      = '0;
        hit_data = '0;
        for (int d = 0; d < NDST; d++) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_dst[l*DST_W +: DST_W] == DST_W'(d + 1)) begin
                    hit[d]                      = 1'b1;
                    hit_data[d*DATA_W +: DATA_W] = lane_data[l*DATA_W +: DATA_W];
                end
            end
        end
    end

    for (genvar d = 0; d < NDST; d++) begin : g_dst
        // Gather within the period, publish and clear at the boundary
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_vld_q[d]                     <= 1'b0;
                stg_data_q[d*DATA_W +: DATA_W]   <= '0;
                out_vld_q[d]                     <= 1'b0;
                out_data_q[d*DATA_W +: DATA_W]   <= '0;
            end else if (boundary) begin
                out_vld_q[d] <= hit[d] | stg_vld_q[d];
                if (hit[d])
                    out_data_q[d*DATA_W +: DATA_W] <= hit_data[d*DATA_W +: DATA_W];
                else if (stg_vld_q[d])
                    out_data_q[d*DATA_W +: DATA_W] <= stg_data_q[d*DATA_W +: DATA_W];
                else
                    out_data_q[d*DATA_W +: DATA_W] <= '0;
                stg_vld_q[d]                   <= 1'b0;
                stg_data_q[d*DATA_W +: DATA_W] <= '0;
            end else if (hit[d]) begin
                stg_vld_q[d]                   <= 1'b1;
                stg_data_q[d*DATA_W +: DATA_W] <= hit_data[d*DATA_W +: DATA_W];
            end
        end

        assert_idle_dest_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !out_vld_q[d] |-> (out_data_q[d*DATA_W +: DATA_W] == '0));
    end

    assign out_data = out_data_q;
    assign out_vld  = out_vld_q;

    assert_outputs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(out_data_q) && $stable(out_vld_q)));

endmodule

// File: rtl/tmx_crossbar.sv
// Module: time-sliced crossbar between a memory port and NUM_UNITS units.
// Assumes: clk is SLOTS times the unit clock and slow_sync marks slot 0;
// unit_out is stable across a slow period; held-back copies of unit outputs
// give one-period pipeline stages between chained units.
module tmx_crossbar
    import xbar_pkg::*;
#(
    parameter int  NUM_UNITS = 4,
    parameter int  DATA_W    = 16,
    parameter int  SLOTS     = 4,
    parameter int  LANES     = 2,
    localparam int SLOT_W    = bits_for(SLOTS),
    localparam int LANE_W    = bits_for(LANES),
    localparam int SRC_W     = bits_for(src_codes(NUM_UNITS)),
    localparam int DST_W     = bits_for(dst_codes(NUM_UNITS))
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        slow_sync,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic [NUM_UNITS*DATA_W-1:0] unit_out,
    input  logic                        cfg_en,
    input  logic                        cfg_wr,
    input  logic [SLOT_W-1:0]           cfg_slot,
    input  logic [LANE_W-1:0]           cfg_lane,
    input  logic [SRC_W-1:0]            cfg_src,
    input  logic [DST_W-1:0]            cfg_dst,
    output logic [NUM_UNITS*DATA_W-1:0] unit_in,
    output logic [NUM_UNITS-1:0]        unit_in_vld,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic                        mem_wvalid
);

    localparam int NDST = NUM_UNITS + 1;

    logic [SLOT_W-1:0]           cur_slot;
    logic                        boundary;
    logic [LANES*SRC_W-1:0]      lane_src;
    logic [LANES*DST_W-1:0]      lane_dst_cfg;
    logic [LANES*DATA_W-1:0]     lane_data;
    logic [LANES*DST_W-1:0]      lane_dst;
    logic [NUM_UNITS*DATA_W-1:0] unit_dly_q;
    logic [NDST*DATA_W-1:0]      dst_data;
    logic [NDST-1:0]             dst_vld;

    xbar_slot_seq #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_sync (slow_sync),
        .cur_slot  (cur_slot),
        .boundary  (boundary)
    );

    xbar_route_table #(
        .SLOTS(SLOTS), .LANES(LANES), .SLOT_W(SLOT_W),
        .LANE_W(LANE_W), .SRC_W(SRC_W), .DST_W(DST_W)
    ) tbl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .cur_slot (cur_slot),
        .cfg_en   (cfg_en),
        .cfg_wr   (cfg_wr),
        .cfg_slot (cfg_slot),
        .cfg_lane (cfg_lane),
        .cfg_src  (cfg_src),
        .cfg_dst  (cfg_dst),
        .lane_src (lane_src),
        .lane_dst (lane_dst_cfg)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        xbar_lane_mux #(
            .NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W), .SRC_W(SRC_W), .DST_W(DST_W)
        ) mux_i (
            .src       (lane_src[l*SRC_W +: SRC_W]),
            .dst       (lane_dst_cfg[l*DST_W +: DST_W]),
            .mem_rdata (mem_rdata),
            .unit_out  (unit_out),
            .unit_dly  (unit_dly_q),
            .lane_data (lane_data[l*DATA_W +: DATA_W]),
            .lane_dst  (lane_dst[l*DST_W +: DST_W])
        );
    end

    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_dly
        // Hold back each unit output by one slow period
        always_ff @(posedge clk) begin
            if (!rst_n)
                unit_dly_q[k*DATA_W +: DATA_W] <= '0;
            else if (boundary)
                unit_dly_q[k*DATA_W +: DATA_W] <= unit_out[k*DATA_W +: DATA_W];
        end
    end

    xbar_dest_hold #(
        .NDST(NDST), .LANES(LANES), .DATA_W(DATA_W), .DST_W(DST_W)
    ) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .lane_data (lane_data),
        .lane_dst  (lane_dst),
        .out_data  (dst_data),
        .out_vld   (dst_vld)
    );

    assign unit_in     = dst_data[NUM_UNITS*DATA_W-1:0];
    assign unit_in_vld = dst_vld[NUM_UNITS-1:0];
    assign mem_wdata   = dst_data[NDST*DATA_W-1 -: DATA_W];
    assign mem_wvalid  = dst_vld[NDST-1];

    assert_dly_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(unit_dly_q));

endmodule

// File: tb/tmx_crossbar_tb_top.sv
// Bench: drives the crossbar on a 250 MHz clock and compares every cycle
// against a behavioural model kept in integer arrays.
module tmx_crossbar_tb_top;

    localparam int N     = 4;
    localparam int W     = 16;
    localparam int SL    = 4;
    localparam int LN    = 2;
    localparam int NDST  = N + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             slow_sync = 1'b0;
    logic [W-1:0]     mem_rdata = '0;
    logic [N*W-1:0]   unit_out = '0;
    logic             cfg_en = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_slot = '0;
    logic [0:0]       cfg_lane = '0;
    logic [3:0]       cfg_src = '0;
    logic [2:0]       cfg_dst = '0;
    logic [N*W-1:0]   unit_in;
    logic [N-1:0]     unit_in_vld;
    logic [W-1:0]     mem_wdata;
    logic             mem_wvalid;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string tag = "R9";
    int    ph = SL - 1;
    bit    sync_on = 1'b1;

    // Model state
    int         sh_src[SL][LN];
    int         sh_dst[SL][LN];
    int         ac_src[SL][LN];
    int         ac_dst[SL][LN];
    logic [W-1:0] st_d[NDST];
    bit         st_v[NDST];
    logic [W-1:0] ex_d[NDST];
    bit         ex_v[NDST];
    logic [W-1:0] dly[N];
    int         m_slot;

    tmx_crossbar #(.NUM_UNITS(N), .DATA_W(W), .SLOTS(SL), .LANES(LN)) dut_i (
        .clk(clk), .rst_n(rst_n), .slow_sync(slow_sync), .mem_rdata(mem_rdata),
        .unit_out(unit_out), .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_slot(cfg_slot),
        .cfg_lane(cfg_lane), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .unit_in(unit_in),
        .unit_in_vld(unit_in_vld), .mem_wdata(mem_wdata), .mem_wvalid(mem_wvalid)
    );

    always #2 clk = ~clk;

    function automatic bit src_valid(input int s);
        return (s >= 1) && (s <= 2 * N + 1);
    endfunction

    function automatic logic [W-1:0] src_word(input int s);
        if (s == 1) return mem_rdata;
        if (s >= 2 && s < 2 + N) return unit_out[(s-2)*W +: W];
        if (s >= 2 + N && s < 2 + 2 * N) return dly[s-2-N];
        return '0;
    endfunction

    // Reference model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SL; s++)
                for (int l = 0; l < LN; l++) begin
                    sh_src[s][l] = 0; sh_dst[s][l] = 0;
                    ac_src[s][l] = 0; ac_dst[s][l] = 0;
                end
            for (int d = 0; d < NDST; d++) begin
                st_d[d] = '0; st_v[d] = 0; ex_d[d] = '0; ex_v[d] = 0;
            end
            for (int k = 0; k < N; k++) dly[k] = '0;
            m_slot = 0;
        end else begin
            int cs;
            bit hit[NDST];
            logic [W-1:0] hv[NDST];
            cs = slow_sync ? 0 : m_slot;
            for (int d = 0; d < NDST; d++) begin hit[d] = 0; hv[d] = '0; end
            for (int l = 0; l < LN; l++) begin
                int s; int d;
                s = ac_src[cs][l];
                d = ac_dst[cs][l];
                if (src_valid(s) && d >= 1 && d <= NDST) begin
                    hit[d-1] = 1;
                    hv[d-1]  = src_word(s);
                end
            end
            if (cs == SL - 1) begin
                for (int d = 0; d < NDST; d++) begin
                    ex_v[d] = hit[d] || st_v[d];
                    ex_d[d] = hit[d] ? hv[d] : (st_v[d] ? st_d[d] : '0);
                    st_v[d] = 0; st_d[d] = '0;
                end
                for (int k = 0; k < N; k++) dly[k] = unit_out[k*W +: W];
                ac_src = sh_src;
                ac_dst = sh_dst;
                m_slot = 0;
            end else begin
                for (int d = 0; d < NDST; d++)
                    if (hit[d]) begin st_v[d] = 1; st_d[d] = hv[d]; end
                m_slot = cs + 1;
            end
            if (cfg_en && cfg_wr) begin
                sh_src[cfg_slot][cfg_lane] = int'(cfg_src);
                sh_dst[cfg_slot][cfg_lane] = int'(cfg_dst);
            end
        end
    end

    task automatic compare();
        logic [N*W-1:0] e_in;
        logic [N-1:0]   e_v;
        for (int k = 0; k < N; k++) begin
            e_in[k*W +: W] = ex_d[k];
            e_v[k] = ex_v[k];
        end
        checks++;
        if (unit_in !== e_in || unit_in_vld !== e_v ||
            mem_wdata !== ex_d[N] || mem_wvalid !== ex_v[N]) begin
            fails++;
            $display("FAIL %s: got in=%h v=%b w=%h wv=%b exp in=%h v=%b w=%h wv=%b",
                     tag, unit_in, unit_in_vld, mem_wdata, mem_wvalid,
                     e_in, e_v, ex_d[N], ex_v[N]);
        end
    endtask

    // One fast cycle: compare after the edge, then drive the next inputs
    task automatic tick();
        @(negedge clk);
        compare();
        cfg_wr    = 1'b0;
        cfg_en    = 1'b0;
        mem_rdata = W'($urandom);
        ph        = (ph + 1) % SL;
        slow_sync = sync_on && (ph == 0);
        if (ph == 0)
            for (int k = 0; k < N; k++) unit_out[k*W +: W] = W'($urandom);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic cfg(input bit en, input int s, input int l, input int src, input int dst);
        cfg_en   = en;
        cfg_wr   = 1'b1;
        cfg_slot = 2'(s);
        cfg_lane = 1'(l);
        cfg_src  = 4'(src);
        cfg_dst  = 3'(dst);
        tick();
    endtask

    initial begin
        // R9: reset state
        tag = "R9";
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(6);

        // R7: write strobe without enable is ignored
        tag = "R7";
        cfg(1'b0, 0, 0, 1, 1);
        cfg(1'b0, 1, 1, 2, 5);
        run(12);

        // R8: writes reach routing only after the next boundary
        tag = "R8";
        cfg(1'b1, 0, 0, 1, 1);
        cfg(1'b1, 1, 0, 3, 5);
        run(8);

        // R2: memory to unit, unit to memory, unit to unit
        tag = "R2";
        cfg(1'b1, 2, 1, 4, 4);
        run(16);

        // R6: held-back unit 0 output feeds unit 1 (chained stage)
        tag = "R6";
        cfg(1'b1, 3, 0, 2 + N + 0, 2);
        cfg(1'b1, 2, 0, 2 + N + 3, 3);
        run(16);

        // R4: higher lane wins in a slot, later slot wins in a period
        tag = "R4";
        cfg(1'b1, 0, 0, 5, 1);
        cfg(1'b1, 0, 1, 1, 1);
        cfg(1'b1, 3, 1, 4, 5);
        run(16);

        // R1: free-running wrap, then a sync pulse that shifts the phase
        tag = "R1";
        sync_on = 1'b0;
        run(12);
        sync_on = 1'b1;
        ph = 1;
        run(14);
        ph = SL - 2;
        run(12);

        // R10: out-of-range source and destination codes leave a lane idle
        tag = "R10";
        cfg(1'b1, 1, 1, 12, 2);
        cfg(1'b1, 2, 1, 1, 7);
        run(16);

        // R5: removing every route to unit 0 leaves it zero and invalid
        tag = "R5";
        cfg(1'b1, 0, 0, 0, 0);
        cfg(1'b1, 0, 1, 0, 0);
        run(12);

        // R3: outputs hold steady across a period while inputs change each cycle
        tag = "R3";
        run(20);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got running exp finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule